// File: doc/BRIEF.md
# Two-Wire Wiper Command Receiver

This block is the receive side of a two-wire serial slave that controls a 32-position digital potentiometer. It watches the clock and data lines, which arrive already synchronized to a fast system clock. It removes short spikes from both lines and finds the start and stop conditions. It then takes in a seven-bit address and, when the address is its own, a command byte and a data byte. It acknowledges each byte it accepts by pulling the data line low through an open-drain enable.

When a complete write frame ends with a stop condition, the block raises a single-cycle command strobe. The strobe carries a decoded operation type and a five-bit wiper code. The strobe goes to a separate register and storage controller, which holds the live and stored wiper values and handles the nonvolatile write timing. The address is made of a fixed upper nibble, two bits set by parameters and one bit taken from an input pin, so up to four of these slaves can share one bus.

Top module: `wiper_cmd_slave`

## Requirements
- R1: A start condition is the filtered data line falling while the filtered clock is high. A stop condition is the data line rising while the clock is high. The idle state of both lines is high, and after reset the block drives nothing onto the bus and raises no strobe.
- R2: The seven received address bits, most significant first, must equal 0,1,0,1, then parameter STRAP_A2, then parameter STRAP_A1, then input addr_pin_i. On a mismatch the block does not acknowledge, and it ignores every later clock until the next start condition.
- R3: The acknowledge is driven through sda_pull_o = 1 (data line held low). It is asserted after the falling clock edge that ends the eighth bit of an accepted byte and released at the falling edge that ends the ninth clock. Both changes happen while the clock is low.
- R4: The eighth address bit selects the transfer type: 0 means write, 1 means no-operation. A matching no-operation address is acknowledged. After it, no further byte is acknowledged and no strobe is produced.
- R5: In a write frame the command byte maps to cmd_op_o as follows: 0x11 gives 0 (set live wiper), 0x21 gives 1 (set stored value only), 0x61 gives 2 (recall stored into live) and 0x51 gives 3 (save live into stored).
- R6: cmd_wiper_o equals data bits D7..D3 of the data byte. Bits D2..D0 have no effect on it.
- R7: Any other command code is still acknowledged, and so is the data byte that follows it, but the frame produces no strobe.
- R8: cmd_valid_o pulses for exactly one cycle, and only after the address, command and data bytes have all been received and a stop condition has been detected. It never pulses before that stop.
- R9: A stop condition, or a repeated start, that arrives before the data byte is complete aborts the frame with no strobe. A repeated start begins a new address phase.
- R10: A low or high pulse on either line that is shorter than FILT_CYCLES system clocks does not reach the protocol logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (as seen on the wire) |
| addr_pin_i | input | 1 | Address pin, least significant address bit |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed command |
| cmd_op_o | output | 2 | Decoded operation, valid with the strobe |
| cmd_wiper_o | output | 5 | Wiper code, valid with the strobe |

## Verification
The bound checker checks several rules on every cycle. The strobe always lasts a single cycle and never overlaps the acknowledge. The acknowledge only starts and ends while the clock line is low. The wiper output holds its value between strobes. Other behaviour can only be shown by the bench's scenarios, because it depends on a whole frame: address matching with the strap and pin bits, the no-operation and unknown-command cases, the command-to-operation mapping, aborts by stop or repeated start, and spike rejection in the middle of a frame.

// File: rtl/wiper_cmd_pkg.sv
package wiper_cmd_pkg;
  localparam int WIPER_W   = 5;
  localparam int BYTE_W    = 8;
  localparam int BITS_MAX  = BYTE_W;
  localparam logic [3:0] ADDR_FIXED = 4'b0101;

  typedef enum logic [1:0] {
    OP_SET_LIVE   = 2'd0,
    OP_SET_STORED = 2'd1,
    OP_RECALL     = 2'd2,
    OP_SAVE       = 2'd3
  } wop_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DATA, ST_WAIT, ST_SKIP
  } rx_state_e;

  typedef struct packed {
    logic known;
    wop_e op;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [BYTE_W-1:0] c);
    cmd_dec_t r;
    r.known = 1'b1;
    r.op    = OP_SET_LIVE;
    case (c)
      8'h11:   r.op = OP_SET_LIVE;
      8'h21:   r.op = OP_SET_STORED;
      8'h61:   r.op = OP_RECALL;
      8'h51:   r.op = OP_SAVE;
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/line_deglitch.sv
module line_deglitch #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (line_i == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(HOLD - 1)) begin
      out_d = line_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/bus_edge_detect.sv
module bus_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_f;
      sda_p_q <= sda_f;
    end
  end

  assign start_o    = scl_f & scl_p_q & sda_p_q & ~sda_f;
  assign stop_o     = scl_f & scl_p_q & ~sda_p_q & sda_f;
  assign scl_rise_o = ~scl_p_q & scl_f;
  assign scl_fall_o = scl_p_q & ~scl_f;
endmodule

// File: rtl/wiper_frame_rx.sv
module wiper_frame_rx
  import wiper_cmd_pkg::*;
#(
  parameter bit STRAP_A2 = 1'b0,
  parameter bit STRAP_A1 = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a0_i,
  input  logic               sda_f,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  output logic               pull_o,
  output logic               valid_o,
  output logic [1:0]         op_o,
  output logic [WIPER_W-1:0] wip_o
);
  rx_state_e          state_q, state_d;
  logic [3:0]         bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0]  shift_q, shift_d;
  logic               ackph_q, ackph_d;
  logic               pull_q, pull_d;
  logic               known_q, known_d;
  wop_e               op_q, op_d;
  logic [WIPER_W-1:0] wip_q, wip_d;
  logic               valid_q, valid_d;
  logic [1:0]         oop_q, oop_d;
  logic [WIPER_W-1:0] owip_q, owip_d;

  logic [6:0] my_addr;
  logic       byte_end;
  logic       in_byte;
  cmd_dec_t   dec;

  assign my_addr  = {ADDR_FIXED, STRAP_A2, STRAP_A1, a0_i};
  assign in_byte  = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_DATA);
  assign byte_end = in_byte && scl_fall_i && !ackph_q && (bitcnt_q == 4'(BITS_MAX));
  assign dec      = decode_cmd(shift_q);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shift_d  = shift_q;
    ackph_d  = ackph_q;
    pull_d   = pull_q;
    known_d  = known_q;
    op_d     = op_q;
    wip_d    = wip_q;
    valid_d  = 1'b0;
    oop_d    = oop_q;
    owip_d   = owip_q;

    if (start_i) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      ackph_d  = 1'b0;
      pull_d   = 1'b0;
      known_d  = 1'b0;
    end else if (stop_i) begin
      if (state_q == ST_WAIT && known_q) begin
        valid_d = 1'b1;
        oop_d   = op_q;
        owip_d  = wip_q;
      end
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      ackph_d  = 1'b0;
      pull_d   = 1'b0;
    end else begin
      if (ackph_q && scl_fall_i) begin
        ackph_d  = 1'b0;
        pull_d   = 1'b0;
        bitcnt_d = '0;
      end
      if (in_byte && scl_rise_i && !ackph_q && (bitcnt_q < 4'(BITS_MAX))) begin
        shift_d  = {shift_q[BYTE_W-2:0], sda_f};
        bitcnt_d = bitcnt_q + 1'b1;
      end
      if (byte_end) begin
        case (state_q)
          ST_ADDR: begin
            if (shift_q[7:1] == my_addr) begin
              pull_d  = 1'b1;
              ackph_d = 1'b1;
              state_d = shift_q[0] ? ST_SKIP : ST_CMD;
            end else begin
              state_d = ST_SKIP;
            end
          end
          ST_CMD: begin
            pull_d  = 1'b1;
            ackph_d = 1'b1;
            known_d = dec.known;
            op_d    = dec.op;
            state_d = ST_DATA;
          end
          ST_DATA: begin
            pull_d  = 1'b1;
            ackph_d = 1'b1;
            wip_d   = shift_q[BYTE_W-1 -: WIPER_W];
            state_d = ST_WAIT;
          end
          default: state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shift_q  <= '0;
      ackph_q  <= 1'b0;
      pull_q   <= 1'b0;
      known_q  <= 1'b0;
      op_q     <= OP_SET_LIVE;
      wip_q    <= '0;
      valid_q  <= 1'b0;
      oop_q    <= '0;
      owip_q   <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shift_q  <= shift_d;
      ackph_q  <= ackph_d;
      pull_q   <= pull_d;
      known_q  <= known_d;
      op_q     <= op_d;
      wip_q    <= wip_d;
      valid_q  <= valid_d;
      oop_q    <= oop_d;
      owip_q   <= owip_d;
    end
  end

  assign pull_o  = pull_q;
  assign valid_o = valid_q;
  assign op_o    = oop_q;
  assign wip_o   = owip_q;
endmodule

// File: rtl/wiper_cmd_slave.sv
module wiper_cmd_slave
  import wiper_cmd_pkg::*;
#(
  parameter int FILT_CYCLES = 4,
  parameter bit STRAP_A2    = 1'b0,
  parameter bit STRAP_A1    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_pin_i,
  output logic               sda_pull_o,
  output logic               cmd_valid_o,
  output logic [1:0]         cmd_op_o,
  output logic [WIPER_W-1:0] cmd_wiper_o
);
  localparam int NLINES = 2;

  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic [NLINES-1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    line_deglitch #(.HOLD(FILT_CYCLES)) u_flt (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  logic start_c, stop_c, rise_c, fall_c;

  bus_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .scl_f      (filt[1]),
    .sda_f      (filt[0]),
    .start_o    (start_c),
    .stop_o     (stop_c),
    .scl_rise_o (rise_c),
    .scl_fall_o (fall_c)
  );

  wiper_frame_rx #(.STRAP_A2(STRAP_A2), .STRAP_A1(STRAP_A1)) u_rx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .a0_i       (addr_pin_i),
    .sda_f      (filt[0]),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .scl_rise_i (rise_c),
    .scl_fall_i (fall_c),
    .pull_o     (sda_pull_o),
    .valid_o    (cmd_valid_o),
    .op_o       (cmd_op_o),
    .wip_o      (cmd_wiper_o)
  );
endmodule

// File: rtl/wiper_cmd_slave_chk.sv
module wiper_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_pull_o,
  input logic       cmd_valid_o,
  input logic [4:0] cmd_wiper_o
);
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R8
  strobe_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (scl_i && sda_i && !sda_pull_o));

  // R3
  ack_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R3
  ack_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> !scl_i);

  // R6
  wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> $stable(cmd_wiper_o));
endmodule

bind wiper_cmd_slave wiper_cmd_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_pull_o  (sda_pull_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_wiper_o (cmd_wiper_o)
);

// File: tb/wiper_cmd_slave_tb.sv
module wiper_cmd_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 4;
  localparam int Q          = 10;
  localparam int NVEC       = 9;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] cmd;
    logic [7:0] data;
    logic       ack_a;
    logic       ack_cd;
    logic       strb;
    logic [1:0] op;
    logic [4:0] wip;
  } vec_t;

  // own address with A2=0, A1=1, pin=1: 0101011 -> write byte 0x56
  localparam vec_t VECS [NVEC] = '{
    '{8'h56, 8'h11, 8'hF8, 1'b1, 1'b1, 1'b1, 2'd0, 5'd31},
    '{8'h56, 8'h21, 8'h07, 1'b1, 1'b1, 1'b1, 2'd1, 5'd0},
    '{8'h56, 8'h61, 8'hA5, 1'b1, 1'b1, 1'b1, 2'd2, 5'd20},
    '{8'h56, 8'h51, 8'h5C, 1'b1, 1'b1, 1'b1, 2'd3, 5'd11},
    '{8'h54, 8'h11, 8'h88, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0},
    '{8'h57, 8'h11, 8'h88, 1'b1, 1'b0, 1'b0, 2'd0, 5'd0},
    '{8'h56, 8'h33, 8'h40, 1'b1, 1'b1, 1'b0, 2'd0, 5'd0},
    '{8'h56, 8'h11, 8'h00, 1'b1, 1'b1, 1'b1, 2'd0, 5'd0},
    '{8'h5E, 8'h11, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0}
  };

  logic clk, rst_n, scl_m, sda_m, a0;
  logic sda_pull, cmd_valid;
  logic [1:0] cmd_op;
  logic [4:0] cmd_wip;
  wire  sda_line = sda_m & ~sda_pull;

  int tests, fails, strobes;
  logic [1:0] last_op;
  logic [4:0] last_wip;

  wiper_cmd_slave #(.FILT_CYCLES(FILT)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .addr_pin_i  (a0),
    .sda_pull_o  (sda_pull),
    .cmd_valid_o (cmd_valid),
    .cmd_op_o    (cmd_op),
    .cmd_wiper_o (cmd_wip)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      strobes  <= strobes + 1;
      last_op  <= cmd_op;
      last_wip <= cmd_wip;
    end
  end

  task automatic chk(input bit ok, input string name, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", name, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_restart();
    w(Q); sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w(Q); sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(3*Q);
  endtask

  // glitch: short SDA low pulse on bit 4 high phase, short SCL low pulse on bit 2
  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      w(Q); sda_m = b[i]; w(Q);
      scl_m = 1'b1;
      if (glitch && i == 4) begin
        w(5); sda_m = 1'b0; w(FILT-1); sda_m = b[i]; w(2*Q-5-(FILT-1));
      end else if (glitch && i == 2) begin
        w(5); scl_m = 1'b0; w(FILT-1); scl_m = 1'b1; w(2*Q-5-(FILT-1));
      end else begin
        w(2*Q);
      end
      scl_m = 1'b0;
    end
    w(Q); sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    ack = sda_pull;
    w(Q); scl_m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit aa, ac, ad;
    int s0;
    tests = 0; fails = 0; strobes = 0;
    scl_m = 1'b1; sda_m = 1'b1; a0 = 1'b1; rst_n = 1'b0;
    w(5); rst_n = 1'b1; w(10);
    // R1: reset state
    chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
    chk(cmd_valid == 1'b0 && strobes == 0, "R1 no strobe after reset", strobes, 0);

    for (int v = 0; v < NVEC; v++) begin
      s0 = strobes;
      bus_start();
      send_byte(VECS[v].addr, 1'b0, aa);
      send_byte(VECS[v].cmd,  1'b0, ac);
      send_byte(VECS[v].data, 1'b0, ad);
      bus_stop();
      // R2 R4 address ack
      chk(aa == VECS[v].ack_a, "R2/R4 address ack", aa, VECS[v].ack_a);
      // R3 R7 command and data ack
      chk(ac == VECS[v].ack_cd && ad == VECS[v].ack_cd, "R3/R7 byte ack", {ac, ad}, {2{VECS[v].ack_cd}});
      // R8 one strobe per good frame
      chk((strobes - s0) == int'(VECS[v].strb), "R8 strobe count", strobes - s0, VECS[v].strb);
      if (VECS[v].strb) begin
        // R5 op mapping, R6 wiper bits
        chk(last_op == VECS[v].op, "R5 op code", last_op, VECS[v].op);
        chk(last_wip == VECS[v].wip, "R6 wiper code", last_wip, VECS[v].wip);
      end
    end

    // R8: no strobe before STOP
    s0 = strobes;
    bus_start();
    send_byte(8'h56, 1'b0, aa);
    send_byte(8'h21, 1'b0, ac);
    send_byte(8'hC8, 1'b0, ad);
    w(40);
    chk(strobes == s0, "R8 no strobe before stop", strobes - s0, 0);
    bus_stop();
    chk(strobes == s0 + 1 && last_wip == 5'd25 && last_op == 2'd1, "R8 strobe at stop", last_wip, 25);

    // R9: STOP after command byte aborts
    s0 = strobes;
    bus_start();
    send_byte(8'h56, 1'b0, aa);
    send_byte(8'h11, 1'b0, ac);
    bus_stop();
    chk(strobes == s0, "R9 stop abort", strobes - s0, 0);

    // R9: repeated START restarts address phase
    s0 = strobes;
    bus_start();
    send_byte(8'h56, 1'b0, aa);
    send_byte(8'h11, 1'b0, ac);
    bus_restart();
    send_byte(8'h56, 1'b0, aa);
    send_byte(8'h21, 1'b0, ac);
    send_byte(8'h98, 1'b0, ad);
    bus_stop();
    chk(aa == 1'b1 && strobes == s0 + 1, "R9 restart single strobe", strobes - s0, 1);
    chk(last_op == 2'd1 && last_wip == 5'd19, "R9 restart values", last_wip, 19);

    // R2: address pin low changes the matching address
    a0 = 1'b0;
    s0 = strobes;
    bus_start();
    send_byte(8'h56, 1'b0, aa);
    send_byte(8'h11, 1'b0, ac);
    send_byte(8'h30, 1'b0, ad);
    bus_stop();
    chk(aa == 1'b0 && strobes == s0, "R2 old address rejected", aa, 0);
    bus_start();
    send_byte(8'h54, 1'b0, aa);
    send_byte(8'h11, 1'b0, ac);
    send_byte(8'h30, 1'b0, ad);
    bus_stop();
    chk(aa == 1'b1 && strobes == s0 + 1 && last_wip == 5'd6, "R2 pin address", last_wip, 6);
    a0 = 1'b1;

    // R10: short spikes on both lines inside the data byte
    s0 = strobes;
    bus_start();
    send_byte(8'h56, 1'b0, aa);
    send_byte(8'h61, 1'b0, ac);
    send_byte(8'h9F, 1'b1, ad);
    bus_stop();
    chk(ad == 1'b1 && strobes == s0 + 1, "R10 frame survives spikes", strobes - s0, 1);
    chk(last_wip == 5'd19 && last_op == 2'd2, "R10 data intact", last_wip, 19);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule